// File: doc/BRIEF.md
# Pixel Stream FIFO and Interrupt Front End

This block is the register and buffering side of a serial RGB pixel driver. Software, or a DMA engine, writes 32-bit pixel words into a register. Each write places one word into a 32-entry queue. A waveform serializer, which sits outside this block, takes the words from the head of the queue through a pop/finish handshake. The block holds the transfer configuration, which is an enable, a colour-order mode and a frame length. It passes that configuration to the serializer.

The block has two service signals. The first is a low-water request: while a frame is running and the queue fill is at or below a programmable trigger level, `dma_req` is high. The same condition sets a request status bit. The second is a frame-finished status bit, which the serializer's done pulse sets. Both status bits can be routed to `irq`. Each has its own enable, and a global enable gates them both. Status bits are cleared by writing one to them. This lets a driver fill the whole queue up front and then top it up with half-depth bursts, either by program writes on interrupt or by DMA bursts.

A small sequencer tracks the frame. It has three states: IDLE, RUN and DONE. IDLE goes to RUN on the first clock on which the enable bit is set. RUN goes to DONE on a serializer done pulse. DONE always goes back to IDLE after one cycle. That cycle sets the finish status and clears the enable bit.

Top module: `pixfeed_front`

## Requirements
- R1: After reset the control register, the interrupt enables and all status bits read 0, the trigger level reads 16, and `irq`, `dma_req` and `px_valid` are 0.
- R2: The control register at offset 0x00 keeps the enable at bit 0, the mode at bits 8:6 and a 13-bit length at bits 28:16. The trigger register at 0x18 keeps bits 4:0. The enable register at 0x1C keeps global (bit 5), request (bit 1) and finish (bit 0). All other bits read 0, and `cfg_en`, `cfg_mode` and `cfg_len` follow the control fields.
- R3: A write to offset 0x14 appends `wr_data` to the queue. `px_valid` is high while the queue holds a word, `px_data` shows the oldest word, and `px_pop` removes it on the clock edge, in first-in first-out order.
- R4: A write to 0x14 while 32 words are held is dropped and sets the sticky overflow status at bit 2 of offset 0x20. The 32 words already held are left unchanged.
- R5: A write that sets the enable bit moves the sequencer from IDLE to RUN on the next edge. A `px_done` pulse in RUN moves it to DONE, and on the edge after that the finish status (bit 0 of 0x20) is set and the enable bit reads 0.
- R6: `dma_req` is high exactly while the sequencer is in RUN and the fill is at or below the trigger level. The request status (bit 1 of 0x20) is set on the next edge.
- R7: Writing one to a status bit clears it on that edge, and writing zero leaves it unchanged. If its set condition holds on the same edge, the set wins.
- R8: `irq` is high when the global enable is set and either the request status or the finish status is set together with its own enable bit.
- R9: A `px_done` pulse outside RUN has no effect on the status or the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, single cycle |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| px_data | output | 32 | Queue head word for the serializer |
| px_valid | output | 1 | Queue not empty |
| px_pop | input | 1 | Serializer takes the head word |
| px_done | input | 1 | Serializer frame-complete pulse |
| cfg_en | output | 1 | Transfer enable bit |
| cfg_mode | output | 3 | Colour-order mode |
| cfg_len | output | 13 | Frame length in pixels |
| dma_req | output | 1 | Low-water service request |
| irq | output | 1 | Interrupt request |

## Verification
Results become due at different times after a stimulus:

- A register write shows in read data and the configuration outputs as soon as its edge has passed.
- `dma_req` and `px_valid` change directly after the edge that changes the fill level.
- The request status and `irq` follow one edge later.
- The finish status appears two edges after the done pulse is sampled, because the sequencer spends one cycle in DONE.

The bench aligns its checks to these delays. It also checks `irq` low before the request status bit lands and high after it. A scoreboard queue holds every word the driver expects the block to accept. A monitor running on the falling edge compares each popped head word with that queue.

// File: rtl/pixfeed_pkg.sv
package pixfeed_pkg;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h20;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned LEN_W  = 13;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_DONE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/pixfeed_fifo.sv
module pixfeed_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             ovf_evt
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf_evt = push && full;
    assign head    = mem[rptr_q];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= ptr_next(wptr_q);
            if (do_pop)  rptr_q <= ptr_next(rptr_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/pixfeed_seq.sv
module pixfeed_seq
    import pixfeed_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic frame_done,
    output logic running,
    output logic finishing
);
    xfer_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (start)      state_d = XS_RUN;
            XS_RUN:  if (frame_done) state_d = XS_DONE;
            XS_DONE:                 state_d = XS_IDLE;
            default:                 state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running   = 1'b0;
        finishing = 1'b0;
        unique case (state_q)
            XS_IDLE: ;
            XS_RUN:  running   = 1'b1;
            XS_DONE: finishing = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pixfeed_regs.sv
module pixfeed_regs
    import pixfeed_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned TRIG_W = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              push,
    input  logic [CNT_W-1:0]  fill,
    input  logic              ovf_evt,
    input  logic              running,
    input  logic              finishing,
    output logic              cfg_en,
    output logic [MODE_W-1:0] cfg_mode,
    output logic [LEN_W-1:0]  cfg_len,
    output logic [2:0]        ien,
    output logic [2:0]        sts,
    output logic              low_water,
    output logic              irq
);
    logic [TRIG_W-1:0] trig_q;
    logic              en_q;
    logic [MODE_W-1:0] mode_q;
    logic [LEN_W-1:0]  len_q;
    logic              ie_glb_q, ie_req_q, ie_fin_q;
    logic              st_fin_q, st_req_q, st_ovf_q;
    logic              wr_ctrl, wr_trig, wr_ien, wr_stat;

    assign wr_ctrl = wr_en && (wr_addr == OFS_CTRL);
    assign wr_trig = wr_en && (wr_addr == OFS_TRIG);
    assign wr_ien  = wr_en && (wr_addr == OFS_IEN);
    assign wr_stat = wr_en && (wr_addr == OFS_STAT);
    assign push    = wr_en && (wr_addr == OFS_DATA);

    assign low_water = running && (fill <= CNT_W'(trig_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mode_q   <= '0;
            len_q    <= '0;
            trig_q   <= TRIG_W'(DEPTH / 2);
            ie_glb_q <= 1'b0;
            ie_req_q <= 1'b0;
            ie_fin_q <= 1'b0;
        end else begin
            if (finishing)    en_q <= 1'b0;
            else if (wr_ctrl) en_q <= wr_data[0];
            if (wr_ctrl) begin
                mode_q <= wr_data[8:6];
                len_q  <= wr_data[28:16];
            end
            if (wr_trig) trig_q <= wr_data[TRIG_W-1:0];
            if (wr_ien) begin
                ie_glb_q <= wr_data[5];
                ie_req_q <= wr_data[1];
                ie_fin_q <= wr_data[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_fin_q <= 1'b0;
            st_req_q <= 1'b0;
            st_ovf_q <= 1'b0;
        end else begin
            if (finishing)                st_fin_q <= 1'b1;
            else if (wr_stat && wr_data[0]) st_fin_q <= 1'b0;
            if (low_water)                st_req_q <= 1'b1;
            else if (wr_stat && wr_data[1]) st_req_q <= 1'b0;
            if (ovf_evt)                  st_ovf_q <= 1'b1;
            else if (wr_stat && wr_data[2]) st_ovf_q <= 1'b0;
        end
    end

    assign irq = ie_glb_q && ((st_req_q && ie_req_q) || (st_fin_q && ie_fin_q));

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL: rd_data = {3'b000, len_q, 7'b0, mode_q, 5'b0, en_q};
            OFS_TRIG: rd_data = 32'(trig_q);
            OFS_IEN:  rd_data = {26'b0, ie_glb_q, 3'b000, ie_req_q, ie_fin_q};
            OFS_STAT: rd_data = {29'b0, st_ovf_q, st_req_q, st_fin_q};
            default:  rd_data = '0;
        endcase
    end

    assign cfg_en   = en_q;
    assign cfg_mode = mode_q;
    assign cfg_len  = len_q;
    assign ien      = {ie_glb_q, ie_req_q, ie_fin_q};
    assign sts      = {st_ovf_q, st_req_q, st_fin_q};
endmodule

// File: rtl/pixfeed_front.sv
module pixfeed_front
    import pixfeed_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [31:0]       px_data,
    output logic              px_valid,
    input  logic              px_pop,
    input  logic              px_done,
    output logic              cfg_en,
    output logic [2:0]        cfg_mode,
    output logic [12:0]       cfg_len,
    output logic              dma_req,
    output logic              irq
);
    logic [CNT_W-1:0] fill_lvl;
    logic             fifo_empty, ovf_evt, push;
    logic             xfer_run, xfer_done;
    logic [2:0]       ie_bits, sts_bits;

    pixfeed_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (px_pop),
        .head      (px_data),
        .count     (fill_lvl),
        .empty     (fifo_empty),
        .ovf_evt   (ovf_evt)
    );

    pixfeed_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cfg_en),
        .frame_done (px_done),
        .running    (xfer_run),
        .finishing  (xfer_done)
    );

    pixfeed_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .push      (push),
        .fill      (fill_lvl),
        .ovf_evt   (ovf_evt),
        .running   (xfer_run),
        .finishing (xfer_done),
        .cfg_en    (cfg_en),
        .cfg_mode  (cfg_mode),
        .cfg_len   (cfg_len),
        .ien       (ie_bits),
        .sts       (sts_bits),
        .low_water (dma_req),
        .irq       (irq)
    );

    assign px_valid = !fifo_empty;
endmodule

// File: rtl/pixfeed_front_chk.sv
module pixfeed_front_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fill_lvl,
    input logic             push_evt,
    input logic             ovf_clr,
    input logic             px_pop,
    input logic             px_valid,
    input logic             dma_req,
    input logic             irq,
    input logic             cfg_en,
    input logic             xfer_run,
    input logic             xfer_done,
    input logic [2:0]       ie_bits,
    input logic [2:0]       sts_bits
);
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= CNT_W'(DEPTH));

    a_r3_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (px_pop && px_valid && !push_evt) |=> (fill_lvl == CNT_W'($past(fill_lvl) - 1'b1)));

    a_r5_done_sets_finish: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (sts_bits[0] && !cfg_en));

    a_r6_req_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_run |-> !dma_req);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_bits[2] && !ovf_clr) |=> sts_bits[2]);

    a_r8_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_bits[2]);
endmodule

bind pixfeed_front pixfeed_front_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_lvl  (fill_lvl),
    .push_evt  (push),
    .ovf_clr   (wr_en && (wr_addr == pixfeed_pkg::OFS_STAT) && wr_data[2]),
    .px_pop    (px_pop),
    .px_valid  (px_valid),
    .dma_req   (dma_req),
    .irq       (irq),
    .cfg_en    (cfg_en),
    .xfer_run  (xfer_run),
    .xfer_done (xfer_done),
    .ie_bits   (ie_bits),
    .sts_bits  (sts_bits)
);

// File: tb/sim_pixfeed_front.sv
`timescale 1ns/1ps
module sim_pixfeed_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] px_data;
    logic        px_valid;
    logic        px_pop = 1'b0;
    logic        px_done = 1'b0;
    logic        cfg_en;
    logic [2:0]  cfg_mode;
    logic [12:0] cfg_len;
    logic        dma_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] sb_q[$];

    always #2.5 clk = ~clk;

    pixfeed_front u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .px_data(px_data), .px_valid(px_valid),
        .px_pop(px_pop), .px_done(px_done), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_len(cfg_len), .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        step(1);
    endtask

    task automatic push_word(input logic [31:0] w);
        if (sb_q.size() < 32) sb_q.push_back(w);
        wr(6'h14, w);
    endtask

    task automatic pop_n(input int n);
        px_pop = 1'b1;
        step(n);
        px_pop = 1'b0;
    endtask

    always @(negedge clk) begin
        if (px_pop && px_valid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3: pop of 0x%08h with no word expected", px_data);
            end else begin
                check("R3 queue order", px_data, sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 dma_req", {31'b0, dma_req}, 0);
        check("R1 px_valid", {31'b0, px_valid}, 0);
        rd(6'h00, v); check("R1 ctrl", v, 0);
        rd(6'h18, v); check("R1 trig", v, 16);
        rd(6'h1C, v); check("R1 ien", v, 0);
        rd(6'h20, v); check("R1 stat", v, 0);

        // R2 field placement and masking
        wr(6'h00, 32'h8000_0000 | (32'd100 << 16) | (32'd5 << 6) | 32'h8);
        rd(6'h00, v); check("R2 ctrl readback", v, (32'd100 << 16) | (32'd5 << 6));
        check("R2 cfg_mode", {29'b0, cfg_mode}, 5);
        check("R2 cfg_len", {19'b0, cfg_len}, 100);
        check("R2 cfg_en", {31'b0, cfg_en}, 0);
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h1C, v); check("R2 ien mask", v, 32'h23);
        wr(6'h1C, 32'h0);
        wr(6'h18, 32'hFF);
        rd(6'h18, v); check("R2 trig mask", v, 32'h1F);
        wr(6'h18, 32'd8);

        // R3 / R4 fill past capacity
        for (int i = 0; i < 33; i++) push_word(32'hA500_0000 + 32'(i * 7));
        check("R3 px_valid", {31'b0, px_valid}, 1);
        check("R3 head", px_data, 32'hA500_0000);
        check("R6 idle no req", {31'b0, dma_req}, 0);
        rd(6'h20, v); check("R4 overflow sticky", v, 32'h4);
        // R7 writing zero keeps, writing one clears
        wr(6'h20, 32'h0);
        rd(6'h20, v); check("R7 zero write keeps", v, 32'h4);
        wr(6'h20, 32'h4);
        rd(6'h20, v); check("R7 one write clears", v, 32'h0);

        // R5 start, R6 low water
        wr(6'h1C, 32'h23);
        wr(6'h00, (32'd24 << 16) | (32'd5 << 6) | 32'h1);
        check("R5 cfg_en set", {31'b0, cfg_en}, 1);
        step(1);
        pop_n(24);
        check("R6 dma_req at trigger", {31'b0, dma_req}, 1);
        check("R8 irq not yet", {31'b0, irq}, 0);
        step(1);
        check("R8 irq after req status", {31'b0, irq}, 1);
        wr(6'h1C, 32'h02);
        check("R8 global gate", {31'b0, irq}, 0);
        wr(6'h1C, 32'h23);
        wr(6'h20, 32'h2);
        rd(6'h20, v); check("R7 set wins over clear", v & 32'h2, 32'h2);
        for (int i = 0; i < 16; i++) push_word(32'h5A00_0000 + 32'(i));
        check("R6 req drops above trigger", {31'b0, dma_req}, 0);
        wr(6'h20, 32'h2);
        rd(6'h20, v); check("R7 req cleared", v, 32'h0);
        check("R8 irq low", {31'b0, irq}, 0);

        // R5 finish
        pop_n(24);
        check("R3 drained", {31'b0, px_valid}, 0);
        px_done = 1'b1;
        step(1);
        px_done = 1'b0;
        check("R5 finish not yet", {31'b0, cfg_en}, 1);
        step(1);
        check("R5 enable cleared", {31'b0, cfg_en}, 0);
        check("R8 irq on finish", {31'b0, irq}, 1);
        check("R6 idle after finish", {31'b0, dma_req}, 0);
        rd(6'h20, v); check("R5 finish status", v, 32'h3);
        rd(6'h00, v); check("R5 ctrl after finish", v, (32'd24 << 16) | (32'd5 << 6));
        wr(6'h20, 32'h3);
        rd(6'h20, v); check("R7 clear both", v, 32'h0);

        // R9 done outside a frame
        px_done = 1'b1;
        step(1);
        px_done = 1'b0;
        step(2);
        rd(6'h20, v); check("R9 stray done stat", v, 32'h0);
        rd(6'h00, v); check("R9 stray done ctrl", v, (32'd24 << 16) | (32'd5 << 6));
        check("R9 irq", {31'b0, irq}, 0);
        check("R3 scoreboard empty", 32'(sb_q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule